// File: doc/BRIEF.md
# Ninth-Bit Recovery from Parity Status

This block sits behind a byte receiver that is set up for 8 data bits with even parity. The far end sends 9 data bits and no parity, so the receiver takes the ninth data bit for a parity bit. For each byte it delivers, this block works out the even-parity bit those 8 bits would need. It XORs that bit with the receiver's parity-error flag, which gives back the ninth bit the sender put on the line. The parity error is used as information, not treated as a fault.

The result is a 9-bit word with a one-cycle valid strobe. The ninth bit sits at the top of the word and is also brought out as an address/data flag for multidrop links. A framing error on a byte blocks that byte and sets a sticky error flag. An optional address filter passes only the data bytes that follow an address byte equal to a programmed station address. The serial deserialiser itself is not part of the block.

Top module: `ninth_bit_rx`

## Requirements
- R1: The recovered ninth bit equals the XOR of all 8 received data bits, XORed with the input parity-error flag. Even parity is the rule that the byte and the expected parity bit together hold an even number of ones.
- R2: A byte accepted with valid_i high and no framing error gives valid_o high for exactly one cycle, in the cycle after the input strobe. word_o then holds the recovered ninth bit at bit 8 and the received byte at bits 7:0.
- R3: is_addr_o is 1 when the delivered word is an address byte (ninth bit 1) and 0 when it is a data byte (ninth bit 0).
- R4: A byte strobed in together with framing_err_i produces no valid_o pulse and leaves the address-filter selection unchanged.
- R5: A framing error sets err_o in the next cycle. err_o then stays at 1 until clr_err_i is sampled high with no new framing error in the same cycle. A framing error arriving in the same cycle as a clear wins, and err_o stays 1.
- R6: With filt_en_i low, every byte without a framing error is delivered.
- R7: With filt_en_i high, address bytes are always delivered. Data bytes are delivered only while the most recent accepted address byte equalled station_addr_i. After reset no address has been matched, so data bytes are dropped.
- R8: Out of reset, valid_o, word_o, is_addr_o and err_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_valid_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received data bits |
| parity_err_i | input | 1 | Receiver parity-error flag for this byte |
| framing_err_i | input | 1 | Receiver framing-error flag for this byte |
| clr_err_i | input | 1 | Clears the sticky error flag |
| filt_en_i | input | 1 | Enables address filtering |
| station_addr_i | input | 8 | Programmed station address |
| word_o | output | 9 | Recovered word: ninth bit at bit 8, byte at 7:0 |
| valid_o | output | 1 | Word strobe |
| is_addr_o | output | 1 | Delivered word is an address byte |
| err_o | output | 1 | Sticky framing-error flag |

## Verification
Every result in this block is due one clock edge after its stimulus. The word and its strobe follow the input strobe by one edge, the sticky flag follows a framing error or a clear by one edge, and a new filter selection applies to the next byte. The bench changes inputs on the falling edge. It samples on the falling edge that follows the rising edge that registers the result. The driver queues every word it expects, and the monitor pops one for each strobe it sees. For a byte that must be dropped, the driver checks on that same falling edge that no strobe is present.

// File: rtl/nb_pkg.sv
package nb_pkg;
  parameter int unsigned DATA_W = 8;
endpackage

// File: rtl/nb_recover.sv
module nb_recover #(
  parameter int unsigned DATA_W = nb_pkg::DATA_W
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              perr_i,
  output logic              ninth_o
);
  logic exp_par;
  // even-parity bit the receiver expected for these data bits
  assign exp_par = ^data_i;
  assign ninth_o = exp_par ^ perr_i;
endmodule

// File: rtl/nb_addr_filter.sv
module nb_addr_filter #(
  parameter int unsigned DATA_W = nb_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic              is_addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] station_i,
  input  logic              en_i,
  output logic              pass_o,
  output logic              sel_o
);
  logic sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else if (evt_i && is_addr_i) sel_q <= (data_i == station_i);
  end

  assign pass_o = !en_i || is_addr_i || sel_q;
  assign sel_o  = sel_q;

  assert_sel_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_i && is_addr_i) |=> $stable(sel_q));
endmodule

// File: rtl/ninth_bit_rx.sv
module ninth_bit_rx #(
  parameter int unsigned DATA_W = nb_pkg::DATA_W,
  localparam int unsigned WORD_W = DATA_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              parity_err_i,
  input  logic              framing_err_i,
  input  logic              clr_err_i,
  input  logic              filt_en_i,
  input  logic [DATA_W-1:0] station_addr_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              is_addr_o,
  output logic              err_o
);
  logic ninth, evt, pass, sel;
  logic [WORD_W-1:0] word_q;
  logic valid_q, err_q;

  assign evt = byte_valid_i && !framing_err_i;

  nb_recover #(.DATA_W(DATA_W)) u_rec (
    .data_i(byte_i), .perr_i(parity_err_i), .ninth_o(ninth)
  );

  nb_addr_filter #(.DATA_W(DATA_W)) u_flt (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt), .is_addr_i(ninth),
    .data_i(byte_i), .station_i(station_addr_i), .en_i(filt_en_i),
    .pass_o(pass), .sel_o(sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= evt && pass;
      if (evt && pass) word_q <= {ninth, byte_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (byte_valid_i && framing_err_i) err_q <= 1'b1;
    else if (clr_err_i) err_q <= 1'b0;
  end

  assign word_o    = word_q;
  assign valid_o   = valid_q;
  assign is_addr_o = word_q[DATA_W];
  assign err_o     = err_q;

  assert_valid_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(byte_valid_i));
  assert_data_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> word_o[DATA_W-1:0] == $past(byte_i));
  assert_ninth_rule_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> word_o[DATA_W] == ((^$past(byte_i)) ^ $past(parity_err_i)));
  assert_ferr_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && framing_err_i |=> !valid_o);
  assert_err_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && framing_err_i |=> err_o);
  assert_err_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !clr_err_i |=> err_o);
  assert_filter_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_en_i && !ninth && !sel |=> !valid_o);
endmodule

// File: tb/ninth_bit_rx_tb.sv
module ninth_bit_rx_tb;
  logic clk = 0, rst_n = 0;
  logic bv = 0, perr = 0, ferr = 0, clr = 0, fen = 0;
  logic [7:0] bt = '0, st = '0;
  logic [8:0] word;
  logic valid, is_addr, err;
  int checks = 0, errors = 0;
  logic [8:0] exp_q[$];
  bit sel_m = 0;

  always #5 clk = ~clk;

  ninth_bit_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(bv), .byte_i(bt),
    .parity_err_i(perr), .framing_err_i(ferr), .clr_err_i(clr),
    .filt_en_i(fen), .station_addr_i(st), .word_o(word), .valid_o(valid),
    .is_addr_o(is_addr), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // sender puts bit9 on line; receiver flags parity error when it breaks even parity
  task automatic send(input logic [7:0] b, input bit b9, input bit fe, input string req);
    bit deliver;
    deliver = !fe && (!fen || b9 || sel_m);
    if (!fe && b9) sel_m = (b == st);
    if (deliver) exp_q.push_back({b9, b});
    bt = b; perr = b9 ^ (^b); ferr = fe; bv = 1;
    @(negedge clk);
    bv = 0; ferr = 0;
    if (!deliver) chk(!valid, req, valid, 0);
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected strobe", word, 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk(word == e, "R1 R2 word", word, e);
        chk(is_addr == e[8], "R3 is_addr", is_addr, e[8]);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
    repeat (2) @(negedge clk);
    chk(valid == 0 && word == 0 && is_addr == 0 && err == 0, "R8 reset", {valid, is_addr, err}, 0);
    rst_n = 1;
    @(negedge clk);
    // R6 unfiltered, all parity combos
    send(8'h00, 0, 0, "R6");
    send(8'h00, 1, 0, "R6");
    send(8'h01, 0, 0, "R6");
    send(8'h01, 1, 0, "R6");
    send(8'hA5, 1, 0, "R6");
    send(8'h7F, 0, 0, "R6");
    send(8'hFF, 1, 0, "R6");
    // R4 / R5 framing error
    send(8'h3C, 1, 1, "R4");
    chk(err == 1, "R5 set", err, 1);
    repeat (3) @(negedge clk);
    chk(err == 1, "R5 hold", err, 1);
    clr = 1; @(negedge clk); clr = 0;
    chk(err == 0, "R5 clear", err, 0);
    // clear and new framing error together: set wins
    clr = 1; bt = 8'h11; ferr = 1; bv = 1;
    @(negedge clk);
    clr = 0; bv = 0; ferr = 0;
    chk(err == 1 && valid == 0, "R5 set wins", err, 1);
    clr = 1; @(negedge clk); clr = 0;
    chk(err == 0, "R5 clear2", err, 0);
    // R7 filter
    st = 8'h42; fen = 1; sel_m = 0;
    send(8'h10, 0, 0, "R7 drop before match");
    send(8'h55, 1, 0, "R7 addr other");
    send(8'h20, 0, 0, "R7 drop other");
    send(8'h42, 1, 0, "R7 addr match");
    send(8'h30, 0, 0, "R7 pass");
    send(8'h31, 0, 0, "R7 pass");
    send(8'h55, 1, 1, "R4 ferr addr no deselect");
    send(8'h32, 0, 0, "R4 still selected");
    send(8'h43, 1, 0, "R7 deselect");
    send(8'h33, 0, 0, "R7 drop after deselect");
    fen = 0;
    send(8'h34, 0, 0, "R6 filter off");
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R2 missing words", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule